// File: doc/BRIEF.md
# Critical-Word-First Cacheline Read Port

This block is the read side of a memory port. A client raises a request with a byte address, a read flag and a transfer-size code. The port answers with an acknowledge, in the same cycle if it can take the request. It then fetches an eight-word line of 32-bit words from an internal backing array. The words go into a read FIFO starting with the word that was addressed. The order wraps round the 32-byte aligned line, so a request at byte 0x4 delivers word indices 1, 2, 3, 4, 5, 6, 7, 0.

The client drains the FIFO with a pop strobe while the empty flag is low. A 2-bit latency setting places each popped word on the data output 0, 1 or 2 cycles after its pop. A 4-bit word-index output travels with each word. A flush input discards everything the port still holds for the current line: queued words, words in the latency stages and the rest of the line load. An initialization-done output gates the whole port after reset.

The backing array stands in for real memory and has a fixed, computed content. The word at word address w, taken from byte address bits [7:2], holds 0x5A000000 + w * 0x00010001.

Top module: `cwf_line_reader`

## Requirements
- R1: `init_done` is low after reset, rises `INIT_CYCLES` clock cycles after reset is released and then stays high. No request is acknowledged while it is low.
- R2: `req_ack` is high in the same cycle as `req_valid` when all of these hold: `req_rnw` is 1, `req_size` is 4'h2, `init_done` is high, no line is loading, `rf_flush` is low, and the FIFO holds at most `FIFO_DEPTH` - 8 words. The request is taken at the clock edge that ends that cycle.
- R3: A request with `req_size` other than 4'h2, or with `req_rnw` at 0, is never acknowledged and places nothing in the FIFO.
- R4: An accepted request returns exactly eight words. The first has index `req_addr[4:2]`, and each later index is the previous one plus 1, modulo 8.
- R5: `rf_word_idx` is {1'b0, index}. The data word is the backing-array word at word address {`req_addr[7:5]`, index}, which holds 0x5A000000 + w * 0x00010001.
- R6: With `rf_latency` at 0, a popped word appears in the cycle of its pop. At 1 it appears one cycle later, and at 2 it appears two cycles later. A setting of 3 acts as 2. In cycles that carry no word, `rf_data` and `rf_word_idx` are zero.
- R7: `rf_empty` is high exactly when the FIFO holds no word. It is high after reset. A pop while empty delivers nothing.
- R8: A cycle with `rf_flush` high empties the FIFO, ends any line load in progress and clears the latency stages. From the next cycle on, no word of the flushed line appears.
- R9: While the FIFO holds more than `FIFO_DEPTH` - 8 words, requests are not acknowledged.
- R10: While a line is being loaded, eight cycles after its acknowledge, no new request is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Address request |
| req_addr | input | 32 | Byte address of the target word, word aligned |
| req_rnw | input | 1 | Read-not-write flag |
| req_size | input | 4 | Transfer size code, 4'h2 is an eight-word line |
| req_ack | output | 1 | Request accepted this cycle |
| init_done | output | 1 | Port ready after reset |
| rf_empty | output | 1 | Read FIFO holds no word |
| rf_pop | input | 1 | Take the next word from the FIFO |
| rf_flush | input | 1 | Discard the current line |
| rf_latency | input | 2 | Pop-to-data delay in cycles |
| rf_data | output | 32 | Returned data word |
| rf_word_idx | output | 4 | Index of the returned word within its line |

## Verification
The assertions assume that the client follows the handshake. It pops only while `rf_empty` is low, holds `rf_latency` steady while words are in flight, and sends word-aligned addresses. The bench sets the latency before each read burst and starts popping only once the whole line is in the FIFO. It drives `req_addr` with bits [1:0] at zero. The one pop made against an empty FIFO is a deliberate test of R7.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
   localparam int DATA_W     = 32;
   localparam int LINE_WORDS = 8;
   localparam int IDX_W      = $clog2(LINE_WORDS);
   localparam int ADDR_LSB   = 2;
   localparam logic [3:0] SIZE_LINE = 4'h2;
   localparam logic [DATA_W-1:0] FILL_BASE = 32'h5A00_0000;
   localparam logic [DATA_W-1:0] FILL_STEP = 32'h0001_0001;

   typedef struct packed {
      logic [IDX_W-1:0]  idx;
      logic [DATA_W-1:0] data;
   } beat_t;
endpackage

// File: rtl/cwf_init_timer.sv
module cwf_init_timer #(
   parameter int INIT_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   output logic done
);
   localparam int CW = $clog2(INIT_CYCLES + 1);
   localparam logic [CW-1:0] LIMIT = CW'(INIT_CYCLES);

   if (INIT_CYCLES < 1) begin : g_bad_init
      $error("INIT_CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (cnt != LIMIT)
         cnt <= cnt + 1'b1;
   end

   assign done = (cnt == LIMIT);
endmodule

// File: rtl/cwf_line_store.sv
module cwf_line_store
   import cwf_pkg::*;
#(
   parameter int MEM_WORDS = 64
) (
   input  logic [$clog2(MEM_WORDS)-1:0] rd_addr,
   output logic [DATA_W-1:0]            rd_data
);
   logic [DATA_W-1:0] mem [MEM_WORDS];

   for (genvar i = 0; i < MEM_WORDS; i++) begin : g_fill
      assign mem[i] = FILL_BASE + DATA_W'(i) * FILL_STEP;
   end

   assign rd_data = mem[rd_addr];
endmodule

// File: rtl/cwf_rd_fifo.sv
module cwf_rd_fifo
   import cwf_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      flush,
   input  logic                      push,
   input  beat_t                     push_beat,
   input  logic                      pop,
   output beat_t                     head,
   output logic                      empty,
   output logic [$clog2(DEPTH):0]    count
);
   localparam int AW = $clog2(DEPTH);

   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("FIFO depth must be a power of two");
   end

   beat_t          q [DEPTH];
   logic [AW-1:0]  wr_ptr, rd_ptr;

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) begin
            q[wr_ptr] <= push_beat;
            wr_ptr    <= wr_ptr + 1'b1;
         end
         if (pop)
            rd_ptr <= rd_ptr + 1'b1;
         count <= count + (push ? 1'b1 : 1'b0) - (pop ? 1'b1 : 1'b0);
      end
   end

   assign head  = q[rd_ptr];
   assign empty = (count == '0);
endmodule

// File: rtl/cwf_lat_pipe.sv
module cwf_lat_pipe
   import cwf_pkg::*;
#(
   parameter int MAX_LAT = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        flush,
   input  logic [1:0]  latency,
   input  logic        pop,
   input  beat_t       head,
   output logic        out_valid,
   output beat_t       out_beat
);
   if (MAX_LAT < 1 || MAX_LAT > 3) begin : g_bad_lat
      $error("MAX_LAT must lie in 1..3");
   end

   logic [MAX_LAT:1] sv;
   beat_t            sb [1:MAX_LAT];
   logic [1:0]       sel;

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         sv <= '0;
      end else begin
         for (int s = 1; s <= MAX_LAT; s++) begin
            if (s == 1) begin
               sv[s] <= pop;
               sb[s] <= head;
            end else begin
               sv[s] <= sv[s-1];
               sb[s] <= sb[s-1];
            end
         end
      end
   end

   assign sel = (32'(latency) > MAX_LAT) ? 2'(MAX_LAT) : latency;

   always_comb begin
      out_valid = 1'b0;
      out_beat  = '0;
      if (sel == 2'd0) begin
         out_valid = pop;
         out_beat  = head;
      end else begin
         for (int s = 1; s <= MAX_LAT; s++) begin
            if (32'(sel) == s) begin
               out_valid = sv[s];
               out_beat  = sb[s];
            end
         end
      end
      if (!out_valid)
         out_beat = '0;
   end
endmodule

// File: rtl/cwf_line_reader.sv
module cwf_line_reader
   import cwf_pkg::*;
#(
   parameter int FIFO_DEPTH  = 16,
   parameter int MEM_WORDS   = 64,
   parameter int INIT_CYCLES = 16,
   parameter int MAX_LAT     = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic [31:0] req_addr,
   input  logic        req_rnw,
   input  logic [3:0]  req_size,
   output logic        req_ack,
   output logic        init_done,
   output logic        rf_empty,
   input  logic        rf_pop,
   input  logic        rf_flush,
   input  logic [1:0]  rf_latency,
   output logic [31:0] rf_data,
   output logic [3:0]  rf_word_idx
);
   localparam int MEM_AW = $clog2(MEM_WORDS);
   localparam int LSEL_W = MEM_AW - IDX_W;
   localparam int CNT_W  = $clog2(FIFO_DEPTH) + 1;
   localparam logic [CNT_W-1:0] ROOM_LIMIT = CNT_W'(FIFO_DEPTH - LINE_WORDS);

   if (FIFO_DEPTH < LINE_WORDS) begin : g_bad_fifo
      $error("FIFO must hold at least one line");
   end
   if (MEM_WORDS < 2 * LINE_WORDS || (1 << MEM_AW) != MEM_WORDS) begin : g_bad_mem
      $error("MEM_WORDS must be a power of two of at least two lines");
   end
   if (ADDR_LSB + MEM_AW > 32) begin : g_bad_addr
      $error("backing array exceeds the address range");
   end

   logic              busy;
   logic [IDX_W-1:0]  beat_cnt, cur_idx;
   logic [LSEL_W-1:0] line_sel;
   logic [CNT_W-1:0]  fifo_count;
   logic [DATA_W-1:0] store_data;
   logic              push, pop_eff, line_req, out_valid;
   beat_t             push_beat, head, out_beat;
   logic              addr_unused;

   assign addr_unused = ^{req_addr[31:ADDR_LSB+MEM_AW], req_addr[ADDR_LSB-1:0]};

   cwf_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_init (
      .clk(clk), .rst_n(rst_n), .done(init_done)
   );

   assign line_req = req_valid && req_rnw && (req_size == SIZE_LINE);
   assign req_ack  = line_req && init_done && !busy && !rf_flush &&
                     (fifo_count <= ROOM_LIMIT);

   always_ff @(posedge clk) begin
      if (!rst_n || rf_flush) begin
         busy     <= 1'b0;
         beat_cnt <= '0;
         cur_idx  <= '0;
         line_sel <= '0;
      end else if (req_ack) begin
         busy     <= 1'b1;
         beat_cnt <= '0;
         cur_idx  <= req_addr[ADDR_LSB +: IDX_W];
         line_sel <= req_addr[ADDR_LSB+IDX_W +: LSEL_W];
      end else if (busy) begin
         cur_idx  <= cur_idx + 1'b1;
         beat_cnt <= beat_cnt + 1'b1;
         if (beat_cnt == IDX_W'(LINE_WORDS - 1))
            busy <= 1'b0;
      end
   end

   cwf_line_store #(.MEM_WORDS(MEM_WORDS)) u_store (
      .rd_addr({line_sel, cur_idx}), .rd_data(store_data)
   );

   assign push      = busy && !rf_flush;
   assign push_beat = '{idx: cur_idx, data: store_data};
   assign pop_eff   = rf_pop && !rf_empty && !rf_flush;

   cwf_rd_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush(rf_flush),
      .push(push), .push_beat(push_beat), .pop(pop_eff),
      .head(head), .empty(rf_empty), .count(fifo_count)
   );

   cwf_lat_pipe #(.MAX_LAT(MAX_LAT)) u_pipe (
      .clk(clk), .rst_n(rst_n), .flush(rf_flush), .latency(rf_latency),
      .pop(pop_eff), .head(head), .out_valid(out_valid), .out_beat(out_beat)
   );

   assign rf_data     = out_beat.data;
   assign rf_word_idx = out_valid ? {1'b0, out_beat.idx} : 4'h0;
endmodule

// File: rtl/cwf_line_reader_chk.sv
module cwf_line_reader_chk #(
   parameter int FIFO_DEPTH = 16,
   parameter int CNT_W      = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_rnw,
   input logic [3:0]       req_size,
   input logic             req_ack,
   input logic             init_done,
   input logic             busy,
   input logic             rf_empty,
   input logic             rf_flush,
   input logic [31:0]      rf_data,
   input logic [3:0]       rf_word_idx,
   input logic [CNT_W-1:0] fifo_count
);
   assert_ack_needs_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |-> init_done);

   assert_init_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);

   assert_ack_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |-> (req_valid && req_rnw && req_size == 4'h2));

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      32'(fifo_count) <= FIFO_DEPTH);

   assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rf_flush |=> rf_empty);

   assert_flush_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rf_flush |=> (rf_data == 32'h0 && rf_word_idx == 4'h0));

   assert_no_ack_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !req_ack);
endmodule

bind cwf_line_reader cwf_line_reader_chk #(
   .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rnw(req_rnw),
   .req_size(req_size), .req_ack(req_ack), .init_done(init_done),
   .busy(busy), .rf_empty(rf_empty), .rf_flush(rf_flush),
   .rf_data(rf_data), .rf_word_idx(rf_word_idx), .fifo_count(fifo_count)
);

// File: tb/cwf_line_reader_test.sv
module cwf_line_reader_test;
   localparam int CLK_PERIOD = 10;
   localparam int INIT_CYCLES = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        req_rnw = 1'b0;
   logic [3:0]  req_size = '0;
   logic        req_ack, init_done, rf_empty;
   logic        rf_pop = 1'b0, rf_flush = 1'b0;
   logic [1:0]  rf_latency = 2'd0;
   logic [31:0] rf_data;
   logic [3:0]  rf_word_idx;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cwf_line_reader #(.INIT_CYCLES(INIT_CYCLES)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_rnw(req_rnw), .req_size(req_size), .req_ack(req_ack),
      .init_done(init_done), .rf_empty(rf_empty), .rf_pop(rf_pop),
      .rf_flush(rf_flush), .rf_latency(rf_latency), .rf_data(rf_data),
      .rf_word_idx(rf_word_idx)
   );

   // addr[31:0], latency[1:0]
   localparam logic [33:0] VEC [7] = '{
      {32'h0000_0004, 2'd0}, {32'h0000_0004, 2'd1}, {32'h0000_0004, 2'd2},
      {32'h0000_001C, 2'd1}, {32'h0000_00A0, 2'd0}, {32'h0000_0074, 2'd3},
      {32'h0000_0108, 2'd2}
   };

   function automatic logic [31:0] fill(input logic [5:0] w);
      return 32'h5A00_0000 + 32'(w) * 32'h0001_0001;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic do_req(input logic [31:0] a, input logic [3:0] sz, input logic rnw,
                         input logic exp_ack, input string req);
      @(posedge clk); #1;
      req_valid = 1'b1; req_addr = a; req_size = sz; req_rnw = rnw;
      @(negedge clk);
      chk(req_ack == exp_ack, req, "req_ack", 32'(req_ack), 32'(exp_ack));
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   // R4 R5 R6: pop eight words back to back and follow the delayed outputs
   task automatic read_line(input logic [31:0] a, input logic [1:0] lat);
      int eff;
      eff = (lat > 2) ? 2 : int'(lat);
      rf_latency = lat;
      for (int c = 0; c < 8 + eff; c++) begin
         @(posedge clk); #1;
         rf_pop = (c < 8);
         @(negedge clk);
         if (c >= eff) begin
            logic [2:0] ix;
            ix = 3'(a[4:2] + 3'(c - eff));
            chk(rf_word_idx == {1'b0, ix}, "R4", "word index",
                32'(rf_word_idx), 32'({1'b0, ix}));
            chk(rf_data == fill({a[7:5], ix}), "R5", "data",
                rf_data, fill({a[7:5], ix}));
         end else begin
            chk(rf_data == 0 && rf_word_idx == 0, "R6", "idle before delay",
                rf_data, 32'h0);
         end
      end
      @(posedge clk); #1;
      rf_pop = 1'b0;
      @(negedge clk);
      chk(rf_empty == 1'b1, "R7", "empty after line", 32'(rf_empty), 32'h1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog (all R): actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      idle(3);
      @(negedge clk);
      chk(rf_empty == 1, "R7", "empty in reset", 32'(rf_empty), 32'h1);
      chk(init_done == 0, "R1", "init_done in reset", 32'(init_done), 32'h0);
      chk(rf_data == 0, "R6", "data in reset", rf_data, 32'h0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      do_req(32'h4, 4'h2, 1'b1, 1'b0, "R1");
      idle(INIT_CYCLES);
      @(negedge clk);
      chk(init_done == 1, "R1", "init_done after wait", 32'(init_done), 32'h1);

      foreach (VEC[i]) begin
         do_req(VEC[i][33:2], 4'h2, 1'b1, 1'b1, "R2");
         idle(10);
         @(negedge clk);
         chk(rf_empty == 0, "R7", "line queued", 32'(rf_empty), 32'h0);
         read_line(VEC[i][33:2], VEC[i][1:0]);
      end

      // R3: wrong size and write requests are refused
      do_req(32'h20, 4'h3, 1'b1, 1'b0, "R3");
      do_req(32'h20, 4'h2, 1'b0, 1'b0, "R3");
      idle(10);
      @(negedge clk);
      chk(rf_empty == 1, "R3", "nothing queued", 32'(rf_empty), 32'h1);

      // R7: pop on empty delivers nothing
      rf_latency = 2'd0;
      @(posedge clk); #1; rf_pop = 1'b1;
      @(negedge clk);
      chk(rf_data == 0 && rf_word_idx == 0, "R7", "pop on empty", rf_data, 32'h0);
      @(posedge clk); #1; rf_pop = 1'b0;

      // R10: request during a line load
      do_req(32'h80, 4'h2, 1'b1, 1'b1, "R2");
      do_req(32'hA0, 4'h2, 1'b1, 1'b0, "R10");
      idle(10);
      read_line(32'h80, 2'd0);

      // R9: two lines fill the FIFO, the third waits for room
      do_req(32'h20, 4'h2, 1'b1, 1'b1, "R2");
      idle(10);
      do_req(32'h44, 4'h2, 1'b1, 1'b1, "R9");
      idle(10);
      do_req(32'h6C, 4'h2, 1'b1, 1'b0, "R9");
      rf_latency = 2'd0;
      for (int k = 0; k < 8; k++) begin
         @(posedge clk); #1; rf_pop = 1'b1;
      end
      @(posedge clk); #1; rf_pop = 1'b0;
      do_req(32'h6C, 4'h2, 1'b1, 1'b1, "R9");
      idle(10);
      for (int k = 0; k < 8; k++) begin
         @(posedge clk); #1; rf_pop = 1'b1;
      end
      @(posedge clk); #1; rf_pop = 1'b0;
      read_line(32'h6C, 2'd1);

      // R8: flush during a load
      do_req(32'h40, 4'h2, 1'b1, 1'b1, "R2");
      idle(2);
      @(posedge clk); #1; rf_flush = 1'b1;
      @(posedge clk); #1; rf_flush = 1'b0;
      @(negedge clk);
      chk(rf_empty == 1, "R8", "empty after flush", 32'(rf_empty), 32'h1);
      idle(12);
      @(negedge clk);
      chk(rf_empty == 1, "R8", "load aborted", 32'(rf_empty), 32'h1);

      // R8: flush cancels a word in the latency stages
      do_req(32'h0, 4'h2, 1'b1, 1'b1, "R2");
      idle(10);
      rf_latency = 2'd2;
      @(posedge clk); #1; rf_pop = 1'b1;
      @(posedge clk); #1; rf_pop = 1'b0; rf_flush = 1'b1;
      @(posedge clk); #1; rf_flush = 1'b0;
      @(negedge clk);
      chk(rf_data == 0 && rf_word_idx == 0, "R8", "delayed word dropped",
          rf_data, 32'h0);
      chk(rf_empty == 1, "R8", "empty after pipeline flush", 32'(rf_empty), 32'h1);

      // R2: port works again after flush
      do_req(32'hE8, 4'h2, 1'b1, 1'b1, "R2");
      idle(10);
      read_line(32'hE8, 2'd1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule